// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Flags

This block holds a small bank of single-bit token flags that two independent ports share. Software on either side takes a token to claim a shared resource and gives it back when done. The hardware decides who holds each token, so the two sides never need a software lock. It is the token section of a dual-port memory. Each port reaches the tokens through its own semaphore select, and only while that port's memory enable is low.

A port writes data bit 0 to act on the addressed flag. A 0 asks for the token and a 1 gives it back. A read returns that port's own view, copied onto every data bit. The byte is all zeros when the reading port holds the token and all ones otherwise. If the other side holds the token, the request is remembered, and the token moves across on the same clock edge as the release. When both sides ask for a free token in the same cycle, the left port always wins and the right port's request waits. The model runs on one clock with a synchronous active-high reset.

Top module: `sema_flag_unit`

## Requirements
- R1: After reset every flag is free and no request is pending. A read of any flag from either port returns 8'hFF.
- R2: A port acts only in a cycle where its sem_sel is 1 and its mem_en is 0. With mem_en at 1, a write changes no flag and a read produces no rvalid.
- R3: On a write (wr=1), only wdata bit 0 counts. Bit 0 equal to 0 requests the flag and bit 0 equal to 1 releases it. Bits 7:1 have no effect.
- R4: A read needs wr=0 and rd_en=1. Its result comes with rvalid on the clock edge that samples the read. rdata is 8'h00 if the reading port holds the flag and 8'hFF otherwise. With rd_en at 0 there is no rvalid.
- R5: A request for a free flag grants it at once. A read issued in the next cycle shows the new owner.
- R6: A request made while the other port holds the flag stays pending. The flag passes to the waiting port on the same edge as the holder's release.
- R7: When both ports request the same free flag in the same cycle, the left port gets it and the right port's request becomes pending.
- R8: A release from a port that does not hold the flag only cancels that port's pending request. The owner is left unchanged.
- R9: addr (values 0 to 7) selects one of eight independent flags. An action on one flag leaves the other seven as they were.
- R10: A flag is never held by both ports. Two reads of the same flag in the same cycle never both return 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lf_sem_sel | input | 1 | Left port semaphore select |
| lf_mem_en | input | 1 | Left port memory enable; 1 blocks semaphore access |
| lf_wr | input | 1 | Left port write (1) or read (0) |
| lf_rd_en | input | 1 | Left port read output enable |
| lf_addr | input | 3 | Left port flag index |
| lf_wdata | input | 8 | Left port write data; bit 0 used |
| lf_rdata | output | 8 | Left port flag view, replicated |
| lf_rvalid | output | 1 | Left port read result valid |
| rt_sem_sel | input | 1 | Right port semaphore select |
| rt_mem_en | input | 1 | Right port memory enable; 1 blocks semaphore access |
| rt_wr | input | 1 | Right port write (1) or read (0) |
| rt_rd_en | input | 1 | Right port read output enable |
| rt_addr | input | 3 | Right port flag index |
| rt_wdata | input | 8 | Right port write data; bit 0 used |
| rt_rdata | output | 8 | Right port flag view, replicated |
| rt_rvalid | output | 1 | Right port read result valid |

## Verification
A write updates flag state on the edge that samples it. A read is captured on the edge that samples it, and its rdata and rvalid are valid after that same edge. A write's effect therefore shows in a read issued in the following cycle. The driver applies inputs just after a rising edge and pushes each expected byte into a per-port queue. The monitor pops the queue only at the falling edge after an rvalid. Any rvalid with an empty queue counts as a failure. This is how the no-rvalid cases of R2 and R4 are caught.

// File: rtl/sema_pkg.sv
package sema_pkg;

    localparam int SEM_FLAGS = 8;
    localparam int SEM_DW    = 8;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    // Per-flag command from one port in one cycle
    typedef struct packed {
        logic req;
        logic rel;
    } flag_cmd_t;

    // Gated port operation
    typedef struct packed {
        logic wr_op;
        logic rd_op;
        logic bit0;
    } port_op_t;

    // A port's view: 0 when it holds the flag, 1 otherwise
    function automatic logic port_view(owner_e own, logic is_left);
        if (is_left) return (own != OWN_LEFT);
        return (own != OWN_RIGHT);
    endfunction

endpackage

// File: rtl/sema_port_gate.sv
module sema_port_gate
    import sema_pkg::*;
#(
    parameter int NUM_FLAGS = SEM_FLAGS,
    parameter int DW        = SEM_DW,
    localparam int AW       = $clog2(NUM_FLAGS)
) (
    input  logic                      sel,
    input  logic                      mem_en,
    input  logic                      wr,
    input  logic                      rd_en,
    input  logic [AW-1:0]             addr,
    input  logic [DW-1:0]             wdata,
    output port_op_t                  op,
    output flag_cmd_t [NUM_FLAGS-1:0] cmds
);

    logic access;
    logic unused_hi;

    assign unused_hi = ^wdata[DW-1:1];
    assign access    = sel & ~mem_en;

    always_comb begin
        op.wr_op = access & wr;
        op.rd_op = access & ~wr & rd_en;
        op.bit0  = wdata[0];
    end

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_dec
        logic hit;
        assign hit         = op.wr_op && (addr == AW'(i));
        assign cmds[i].req = hit & ~op.bit0;
        assign cmds[i].rel = hit &  op.bit0;
    end

endmodule

// File: rtl/sema_flag_cell.sv
module sema_flag_cell
    import sema_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flag_cmd_t cmd_l,
    input  flag_cmd_t cmd_r,
    output owner_e    owner
);

    logic   pend_l, pend_r;
    logic   want_l, want_r;
    logic   keep_l, keep_r;
    owner_e owner_nx;
    logic   pend_l_nx, pend_r_nx;

    always_comb begin
        want_l = cmd_l.req | (pend_l & ~cmd_l.rel);
        want_r = cmd_r.req | (pend_r & ~cmd_r.rel);
        keep_l = (owner == OWN_LEFT)  & ~cmd_l.rel;
        keep_r = (owner == OWN_RIGHT) & ~cmd_r.rel;
        owner_nx  = OWN_NONE;
        pend_l_nx = 1'b0;
        pend_r_nx = 1'b0;
        if (keep_l) begin
            owner_nx  = OWN_LEFT;
            pend_r_nx = want_r;
        end else if (keep_r) begin
            owner_nx  = OWN_RIGHT;
            pend_l_nx = want_l;
        end else if (want_l) begin
            owner_nx  = OWN_LEFT;
            pend_r_nx = want_r;
        end else if (want_r) begin
            owner_nx  = OWN_RIGHT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            owner  <= OWN_NONE;
            pend_l <= 1'b0;
            pend_r <= 1'b0;
        end else begin
            owner  <= owner_nx;
            pend_l <= pend_l_nx;
            pend_r <= pend_r_nx;
        end
    end

    // R6: a waiting request implies the other side holds the flag
    a_r6_pend_has_holder: assert property (@(posedge clk) disable iff (rst)
        (pend_l |-> owner == OWN_RIGHT) and (pend_r |-> owner == OWN_LEFT));
    // R10: never both sides waiting
    a_r10_pend_excl: assert property (@(posedge clk) disable iff (rst)
        !(pend_l && pend_r));
    // R6: handoff on release
    a_r6_handoff_l2r: assert property (@(posedge clk) disable iff (rst)
        (owner == OWN_LEFT && cmd_l.rel && pend_r) |=> owner == OWN_RIGHT);
    a_r6_handoff_r2l: assert property (@(posedge clk) disable iff (rst)
        (owner == OWN_RIGHT && cmd_r.rel && pend_l) |=> owner == OWN_LEFT);
    // R7: tie goes left
    a_r7_tie_left: assert property (@(posedge clk) disable iff (rst)
        (owner == OWN_NONE && cmd_l.req && cmd_r.req) |=> owner == OWN_LEFT);
    // R5: free flag granted at once
    a_r5_grant_right: assert property (@(posedge clk) disable iff (rst)
        (owner == OWN_NONE && !cmd_l.req && cmd_r.req) |=> owner == OWN_RIGHT);
    // R8: non-owner release leaves owner alone
    a_r8_foreign_rel: assert property (@(posedge clk) disable iff (rst)
        (owner == OWN_LEFT && cmd_r.rel && !cmd_l.rel) |=> owner == OWN_LEFT);

endmodule

// File: rtl/sema_read_port.sv
module sema_read_port
    import sema_pkg::*;
#(
    parameter int   NUM_FLAGS = SEM_FLAGS,
    parameter int   DW        = SEM_DW,
    parameter logic IS_LEFT   = 1'b1,
    localparam int  AW        = $clog2(NUM_FLAGS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   rd_op,
    input  logic [AW-1:0]          addr,
    input  owner_e [NUM_FLAGS-1:0] owners,
    output logic [DW-1:0]          rdata,
    output logic                   rvalid
);

    logic view;
    assign view = port_view(owners[addr], IS_LEFT);

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '1;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_op;
            if (rd_op) rdata <= {DW{view}};
        end
    end

    // R4: result is always a replicated single bit
    a_r4_replicated: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> (rdata == '0 || rdata == '1));

endmodule

// File: rtl/sema_flag_unit.sv
module sema_flag_unit
    import sema_pkg::*;
#(
    parameter int  NUM_FLAGS = SEM_FLAGS,
    parameter int  DW        = SEM_DW,
    localparam int AW        = $clog2(NUM_FLAGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lf_sem_sel,
    input  logic          lf_mem_en,
    input  logic          lf_wr,
    input  logic          lf_rd_en,
    input  logic [AW-1:0] lf_addr,
    input  logic [DW-1:0] lf_wdata,
    output logic [DW-1:0] lf_rdata,
    output logic          lf_rvalid,
    input  logic          rt_sem_sel,
    input  logic          rt_mem_en,
    input  logic          rt_wr,
    input  logic          rt_rd_en,
    input  logic [AW-1:0] rt_addr,
    input  logic [DW-1:0] rt_wdata,
    output logic [DW-1:0] rt_rdata,
    output logic          rt_rvalid
);

    port_op_t                  op_l, op_r;
    flag_cmd_t [NUM_FLAGS-1:0] cmd_l, cmd_r;
    owner_e    [NUM_FLAGS-1:0] owners;

    sema_port_gate #(.NUM_FLAGS(NUM_FLAGS), .DW(DW)) u_gate_l (
        .sel(lf_sem_sel), .mem_en(lf_mem_en), .wr(lf_wr), .rd_en(lf_rd_en),
        .addr(lf_addr), .wdata(lf_wdata), .op(op_l), .cmds(cmd_l)
    );

    sema_port_gate #(.NUM_FLAGS(NUM_FLAGS), .DW(DW)) u_gate_r (
        .sel(rt_sem_sel), .mem_en(rt_mem_en), .wr(rt_wr), .rd_en(rt_rd_en),
        .addr(rt_addr), .wdata(rt_wdata), .op(op_r), .cmds(cmd_r)
    );

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        sema_flag_cell u_cell (
            .clk(clk), .rst(rst),
            .cmd_l(cmd_l[i]), .cmd_r(cmd_r[i]),
            .owner(owners[i])
        );
    end

    sema_read_port #(.NUM_FLAGS(NUM_FLAGS), .DW(DW), .IS_LEFT(1'b1)) u_rd_l (
        .clk(clk), .rst(rst), .rd_op(op_l.rd_op), .addr(lf_addr),
        .owners(owners), .rdata(lf_rdata), .rvalid(lf_rvalid)
    );

    sema_read_port #(.NUM_FLAGS(NUM_FLAGS), .DW(DW), .IS_LEFT(1'b0)) u_rd_r (
        .clk(clk), .rst(rst), .rd_op(op_r.rd_op), .addr(rt_addr),
        .owners(owners), .rdata(rt_rdata), .rvalid(rt_rvalid)
    );

    // R2: blocked access yields no read result
    a_r2_blocked_left: assert property (@(posedge clk) disable iff (rst)
        (lf_sem_sel && lf_mem_en) |=> !lf_rvalid);
    a_r2_blocked_right: assert property (@(posedge clk) disable iff (rst)
        (rt_sem_sel && rt_mem_en) |=> !rt_rvalid);
    // R10: same flag read by both sides never shows two owners
    a_r10_single_owner: assert property (@(posedge clk) disable iff (rst)
        (lf_rvalid && rt_rvalid && lf_rdata == '0) |-> rt_rdata != '0 ||
        $past(lf_addr) != $past(rt_addr));

endmodule

// File: tb/sema_flag_unit_tb.sv
`timescale 1ns/1ps
module sema_flag_unit_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       lf_sem_sel, lf_mem_en, lf_wr, lf_rd_en;
    logic [2:0] lf_addr;
    logic [7:0] lf_wdata, lf_rdata;
    logic       lf_rvalid;
    logic       rt_sem_sel, rt_mem_en, rt_wr, rt_rd_en;
    logic [2:0] rt_addr;
    logic [7:0] rt_wdata, rt_rdata;
    logic       rt_rvalid;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_l[$];
    logic [7:0] exp_r[$];
    string      tag_l[$];
    string      tag_r[$];

    always #2.5 clk = ~clk;

    sema_flag_unit u_dut (
        .clk(clk), .rst(rst),
        .lf_sem_sel(lf_sem_sel), .lf_mem_en(lf_mem_en), .lf_wr(lf_wr),
        .lf_rd_en(lf_rd_en), .lf_addr(lf_addr), .lf_wdata(lf_wdata),
        .lf_rdata(lf_rdata), .lf_rvalid(lf_rvalid),
        .rt_sem_sel(rt_sem_sel), .rt_mem_en(rt_mem_en), .rt_wr(rt_wr),
        .rt_rd_en(rt_rd_en), .rt_addr(rt_addr), .rt_wdata(rt_wdata),
        .rt_rdata(rt_rdata), .rt_rvalid(rt_rvalid)
    );

    task automatic idle();
        lf_sem_sel = 0; lf_mem_en = 0; lf_wr = 0; lf_rd_en = 0; lf_addr = 0; lf_wdata = 0;
        rt_sem_sel = 0; rt_mem_en = 0; rt_wr = 0; rt_rd_en = 0; rt_addr = 0; rt_wdata = 0;
    endtask

    task automatic step();
        @(posedge clk); #1;
        idle();
    endtask

    task automatic set_l(input logic s, input logic m, input logic w, input logic o,
                         input logic [2:0] a, input logic [7:0] d);
        lf_sem_sel = s; lf_mem_en = m; lf_wr = w; lf_rd_en = o; lf_addr = a; lf_wdata = d;
    endtask

    task automatic set_r(input logic s, input logic m, input logic w, input logic o,
                         input logic [2:0] a, input logic [7:0] d);
        rt_sem_sel = s; rt_mem_en = m; rt_wr = w; rt_rd_en = o; rt_addr = a; rt_wdata = d;
    endtask

    // Read the same flag from both sides and queue the expected views
    task automatic rd_both(input logic [2:0] a, input logic [7:0] el,
                           input logic [7:0] er, input string tag);
        set_l(1, 0, 0, 1, a, 8'h00);
        set_r(1, 0, 0, 1, a, 8'h00);
        exp_l.push_back(el); tag_l.push_back(tag);
        exp_r.push_back(er); tag_r.push_back(tag);
        step();
    endtask

    // Monitor: results are due after the edge that sampled the read
    always @(negedge clk) begin
        if (!rst) begin
            if (lf_rvalid) begin
                checks++;
                if (exp_l.size() == 0) begin
                    errors++;
                    $display("FAIL R2/R4 left: unexpected rvalid, rdata %h expected none", lf_rdata);
                end else begin
                    automatic logic [7:0] e = exp_l.pop_front();
                    automatic string t = tag_l.pop_front();
                    if (lf_rdata !== e) begin
                        errors++;
                        $display("FAIL %s left: rdata %h expected %h", t, lf_rdata, e);
                    end
                end
            end
            if (rt_rvalid) begin
                checks++;
                if (exp_r.size() == 0) begin
                    errors++;
                    $display("FAIL R2/R4 right: unexpected rvalid, rdata %h expected none", rt_rdata);
                end else begin
                    automatic logic [7:0] e = exp_r.pop_front();
                    automatic string t = tag_r.pop_front();
                    if (rt_rdata !== e) begin
                        errors++;
                        $display("FAIL %s right: rdata %h expected %h", t, rt_rdata, e);
                    end
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: all flags free after reset
        for (int i = 0; i < 8; i++) rd_both(3'(i), 8'hFF, 8'hFF, "R1");

        // R5: left takes free flag 2
        set_l(1, 0, 1, 0, 3'd2, 8'hFE); step();
        rd_both(3'd2, 8'h00, 8'hFF, "R5/R10");

        // R6: right waits, then receives on left release
        set_r(1, 0, 1, 0, 3'd2, 8'h00); step();
        rd_both(3'd2, 8'h00, 8'hFF, "R6 pending");
        set_l(1, 0, 1, 0, 3'd2, 8'h01); step();
        rd_both(3'd2, 8'hFF, 8'h00, "R6 handoff");

        // R8: left queues then withdraws; right release frees flag
        set_l(1, 0, 1, 0, 3'd2, 8'h00); step();
        set_l(1, 0, 1, 0, 3'd2, 8'h01); step();
        rd_both(3'd2, 8'hFF, 8'h00, "R8 owner kept");
        set_r(1, 0, 1, 0, 3'd2, 8'h01); step();
        rd_both(3'd2, 8'hFF, 8'hFF, "R8 withdrawn");

        // R7: same-cycle tie on flag 5
        set_l(1, 0, 1, 0, 3'd5, 8'h00);
        set_r(1, 0, 1, 0, 3'd5, 8'h00); step();
        rd_both(3'd5, 8'h00, 8'hFF, "R7 tie");
        set_l(1, 0, 1, 0, 3'd5, 8'h01); step();
        rd_both(3'd5, 8'hFF, 8'h00, "R7 waiter");
        set_r(1, 0, 1, 0, 3'd5, 8'h01); step();

        // R3: only bit 0 matters
        set_l(1, 0, 1, 0, 3'd3, 8'hAA); step();
        rd_both(3'd3, 8'h00, 8'hFF, "R3 request");
        set_l(1, 0, 1, 0, 3'd3, 8'h55); step();
        rd_both(3'd3, 8'hFF, 8'hFF, "R3 release");

        // R2: blocked write and read, unselected write
        set_l(1, 1, 1, 0, 3'd4, 8'h00); step();
        set_l(1, 1, 0, 1, 3'd4, 8'h00); step();
        set_r(0, 0, 1, 0, 3'd4, 8'h00); step();
        rd_both(3'd4, 8'hFF, 8'hFF, "R2");

        // R4: read without output enable gives nothing
        set_l(1, 0, 0, 0, 3'd4, 8'h00);
        set_r(1, 0, 0, 0, 3'd4, 8'h00); step();

        // R9: independent flags
        set_l(1, 0, 1, 0, 3'd0, 8'h00);
        set_r(1, 0, 1, 0, 3'd1, 8'h00); step();
        set_l(1, 0, 1, 0, 3'd7, 8'h00); step();
        for (int i = 0; i < 8; i++)
            rd_both(3'(i), (i == 0 || i == 7) ? 8'h00 : 8'hFF,
                    (i == 1) ? 8'h00 : 8'hFF, "R9");

        repeat (3) step();
        checks++;
        if (exp_l.size() != 0 || exp_r.size() != 0) begin
            errors++;
            $display("FAIL R4: pending results left %0d right %0d expected 0",
                     exp_l.size(), exp_r.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule